// File: doc/BRIEF.md
# Sticky Interrupt Status Controller with Zero-Write Clear

This block collects the event pulses that a multi-channel converter's sequencing logic raises when a channel finishes a conversion or when a conversion runs out of time. Each event lands in its own sticky bit of a status register and stays there until software removes it. Reading the status register never disturbs it. Software removes a bit by writing a word that holds 0 at that bit's position; positions written with 1 keep their value, so one write can acknowledge exactly the events it has handled without a read-modify-write race.

Two configuration registers share the status register's bit layout. The record-enable register decides whether an event may enter the status register at all. The line-enable register decides which recorded bits reach the single interrupt output. A bit can therefore be recorded and polled without ever raising the line. The interrupt output is a register fed by the OR of status AND line-enable, so it follows the status by one clock.

Top module: `wzc_irq_ctrl`

## Requirements
- R1: After reset the status, record-enable and line-enable registers all read 0 and `irq` is low.
- R2: A `done_pulse[i]` high in a cycle where record-enable bit 8+i is 1 sets status bit 8+i at that clock edge; a `tmo_pulse[i]` likewise sets status bit 16+i when record-enable bit 16+i is 1 (channels i = 0..3).
- R3: A set pulse whose record-enable bit is 0 in that cycle leaves the status bit unchanged.
- R4: A status bit that is set stays set, over any number of idle cycles and any number of reads, until a clearing write.
- R5: A write to the status register (`reg_addr` = 0) clears every status bit whose `reg_wdata` bit is 0 and leaves every bit whose `reg_wdata` bit is 1 unchanged.
- R6: When a set pulse (with its record-enable bit on) and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: The record-enable register (`reg_addr` = 1) and line-enable register (`reg_addr` = 2) store a written word in bits 8..11 and 16..19 only; all other bits read 0, so writing 0xFFFFFFFF reads back 0x000F0F00. They keep their value when not written.
- R8: `irq` after a clock edge equals the OR over all bits of (status AND line-enable) as they stood before that edge, so it rises one cycle after the status bit and falls one cycle after the clear.
- R9: A recorded status bit whose line-enable bit is 0 is still visible in the status register but does not raise `irq`.
- R10: Status bits outside 8..11 and 16..19 always read 0, and reads at `reg_addr` = 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_pulse | input | 4 | Per-channel conversion-finished set pulse |
| tmo_pulse | input | 4 | Per-channel conversion-timeout set pulse |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | 2 | Register select: 0 status, 1 record-enable, 2 line-enable, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational, no side effect |
| irq | output | 1 | Interrupt line, registered |

## Verification
A set pulse or a register write takes effect at the clock edge of the cycle that carries it, so the status and configuration readback is due one edge later, while `irq` is due one further edge later because it is registered from the status. The bench drives every input 1 ns after a rising edge and samples `reg_rdata` and `irq` a little later in the same low-to-high span, checking the status right after the pulse edge and the line only after the following edge. The clear-versus-set collision and the line's falling edge are checked on the exact edge where each is due, including the cycle in which `irq` must still be high after the clear.

// File: rtl/wzc_pkg.sv
package wzc_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_ENABLE = 2'd1,
        ADDR_SIGEN  = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

    // Contiguous field of n ones starting at bit lsb.
    function automatic logic [REG_W-1:0] field_mask(input int lsb, input int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            m[i] = (i >= lsb) && (i < lsb + n);
        end
        return m;
    endfunction

endpackage

// File: rtl/wzc_cfg_reg.sv
module wzc_cfg_reg #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] val;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.val = wdata & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.val;

    // R7: a write lands in the implemented bits only
    p_cfg_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == ($past(wdata) & MASK)));

    // R7: without a write the register holds
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/wzc_status_bank.sv
module wzc_status_bank #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] en_vec,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] bits;
    } stat_state_t;

    stat_state_t  s_d, s_q;
    logic [W-1:0] set_hit;
    logic [W-1:0] clr_hit;

    assign set_hit = set_vec & en_vec;
    assign clr_hit = {W{wr_en}} & ~wdata;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < W; i++) begin
            if (set_hit[i]) begin
                s_d.bits[i] = 1'b1;
            end else if (clr_hit[i]) begin
                s_d.bits[i] = 1'b0;
            end
        end
        s_d.bits = s_d.bits & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.bits;

    for (genvar g = 0; g < W; g++) begin : g_bit_chk
        if (MASK[g]) begin : g_impl
            // R4: a set bit survives every cycle without a zero write
            p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (q[g] && !(wr_en && !wdata[g])) |=> q[g]);

            // R2, R6: an enabled pulse always leaves the bit set
            p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (set_vec[g] && en_vec[g]) |=> q[g]);

            // R3: a clear bit stays clear without an enabled pulse
            p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!q[g] && !(set_vec[g] && en_vec[g])) |=> !q[g]);

            // R5: zero write clears when no enabled pulse competes
            p_zero_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !wdata[g] && !(set_vec[g] && en_vec[g])) |=> !q[g]);
        end else begin : g_rsvd
            // R10: reserved positions never hold a one
            p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> !q[g]);
        end
    end

endmodule

// File: rtl/wzc_irq_merge.sv
module wzc_irq_merge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic [W-1:0] sig_en,
    output logic         irq
);

    typedef struct packed {
        logic line;
    } irq_state_t;

    irq_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.line = |(status & sig_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.line;

    // R8: the line reflects the previous cycle's masked status
    p_irq_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & sig_en)) |=> irq);

    // R9: with nothing passed through the signal mask the line stays low
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & sig_en) == '0) |=> !irq);

endmodule

// File: rtl/wzc_irq_ctrl.sv
module wzc_irq_ctrl
    import wzc_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DONE_LSB = 8,
    parameter int TMO_LSB  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done_pulse,
    input  logic [NUM_CH-1:0] tmo_pulse,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);

    localparam logic [REG_W-1:0] IMPL_MASK =
        field_mask(DONE_LSB, NUM_CH) | field_mask(TMO_LSB, NUM_CH);

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] sig_q;
    logic [REG_W-1:0] stat_q;
    logic             wr_stat;
    logic             wr_en_reg;
    logic             wr_sig_reg;

    assign wr_stat    = reg_wr && (reg_addr == ADDR_STATUS);
    assign wr_en_reg  = reg_wr && (reg_addr == ADDR_ENABLE);
    assign wr_sig_reg = reg_wr && (reg_addr == ADDR_SIGEN);

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            set_vec[DONE_LSB + i] = done_pulse[i];
            set_vec[TMO_LSB + i]  = tmo_pulse[i];
        end
    end

    wzc_cfg_reg #(.W(REG_W), .MASK(IMPL_MASK)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en_reg),
        .wdata (reg_wdata),
        .q     (en_q)
    );

    wzc_cfg_reg #(.W(REG_W), .MASK(IMPL_MASK)) u_sigen (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_sig_reg),
        .wdata (reg_wdata),
        .q     (sig_q)
    );

    wzc_status_bank #(.W(REG_W), .MASK(IMPL_MASK)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .en_vec  (en_q),
        .wr_en   (wr_stat),
        .wdata   (reg_wdata),
        .q       (stat_q)
    );

    wzc_irq_merge #(.W(REG_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (stat_q),
        .sig_en (sig_q),
        .irq    (irq)
    );

    always_comb begin
        case (reg_addr)
            ADDR_STATUS: reg_rdata = stat_q;
            ADDR_ENABLE: reg_rdata = en_q;
            ADDR_SIGEN:  reg_rdata = sig_q;
            default:     reg_rdata = '0;
        endcase
    end

    // R10: status reads never show reserved positions
    p_status_read_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STATUS) |-> ((reg_rdata & ~IMPL_MASK) == '0));

    // R2: a pulse gated off by the enable register leaves the done field as is
    p_done_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && ((set_vec & en_q) == '0)) |=> $stable(stat_q));

endmodule

// File: tb/wzc_irq_ctrl_test.sv
module wzc_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  done_pulse = '0;
    logic [3:0]  tmo_pulse = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wzc_irq_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_pulse (done_pulse),
        .tmo_pulse  (tmo_pulse),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] sig;
        logic [3:0]  done;
        logic [3:0]  tmo;
        logic [31:0] st;
        logic        irq;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h000F0F00, 32'h000F0F00, 4'b0001, 4'b0000, 32'h00000100, 1'b1}, // R2 R8
        '{32'h000F0F00, 32'h00000000, 4'b1010, 4'b0000, 32'h00000A00, 1'b0}, // R9
        '{32'h00000F00, 32'h000F0F00, 4'b0000, 4'b0011, 32'h00000000, 1'b0}, // R3
        '{32'h000F0000, 32'h00080000, 4'b1111, 4'b1000, 32'h00080000, 1'b1}, // R2 R3
        '{32'h00000500, 32'h00000400, 4'b1111, 4'b0000, 32'h00000500, 1'b1}, // R3 R8
        '{32'h000F0F00, 32'h00000100, 4'b0010, 4'b0100, 32'h00040200, 1'b0}  // R2 R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        cyc();
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] dn, input logic [3:0] tm);
        done_pulse = dn;
        tmo_pulse  = tm;
        cyc();
        done_pulse = '0;
        tmo_pulse  = '0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1: reset state
        rd(2'd0, v); chk("R1 status", v, 32'h0);
        rd(2'd1, v); chk("R1 enable", v, 32'h0);
        rd(2'd2, v); chk("R1 sigen", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3: with enable zero nothing is recorded
        pulse(4'hF, 4'hF);
        rd(2'd0, v); chk("R3 gated after reset", v, 32'h0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            wr(2'd1, VECS[k].en);
            wr(2'd2, VECS[k].sig);
            wr(2'd0, 32'h0);
            cyc();
            pulse(VECS[k].done, VECS[k].tmo);
            rd(2'd0, v); chk($sformatf("R2 vec%0d status", k), v, VECS[k].st);
            cyc();
            chk($sformatf("R8 vec%0d irq", k), {31'b0, irq}, {31'b0, VECS[k].irq});
        end

        // R7: config registers keep only implemented bits
        wr(2'd1, 32'hFFFFFFFF);
        rd(2'd1, v); chk("R7 enable readback", v, 32'h000F0F00);
        wr(2'd2, 32'h00000000);
        rd(2'd2, v); chk("R7 sigen readback", v, 32'h0);
        rd(2'd1, v); chk("R7 enable holds", v, 32'h000F0F00);
        rd(2'd3, v); chk("R10 unused address", v, 32'h0);

        // R4: sticky through idle and reads
        wr(2'd0, 32'h0);
        pulse(4'hF, 4'hF);
        rd(2'd0, v); chk("R2 all set", v, 32'h000F0F00);
        repeat (5) cyc();
        rd(2'd0, v); chk("R4 sticky idle", v, 32'h000F0F00);
        rd(2'd0, v); chk("R4 repeated read", v, 32'h000F0F00);

        // R5: ones keep, zeros clear
        wr(2'd0, 32'hFFFFFFFF);
        rd(2'd0, v); chk("R5 ones keep", v, 32'h000F0F00);
        wr(2'd0, 32'hFFFFFEFF);
        rd(2'd0, v); chk("R5 single clear", v, 32'h000F0E00);
        rd(2'd3, v); chk("R10 unused after writes", v, 32'h0);

        // R6: set wins over a simultaneous clear
        done_pulse = 4'b0010;
        wr(2'd0, 32'h0);
        done_pulse = '0;
        rd(2'd0, v); chk("R6 set wins", v, 32'h00000200);

        // R8: line rise and fall timing
        wr(2'd2, 32'h00000200);
        cyc();
        chk("R8 irq high", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R5 cleared", v, 32'h0);
        chk("R8 irq still high on clear edge", {31'b0, irq}, 32'h1);
        cyc();
        chk("R8 irq low one cycle later", {31'b0, irq}, 32'h0);

        // R9: recorded but masked bit keeps line low
        wr(2'd2, 32'h00010000);
        pulse(4'b0000, 4'b0010);
        rd(2'd0, v); chk("R9 recorded", v, 32'h00020000);
        cyc();
        chk("R9 irq masked", {31'b0, irq}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule